// File: doc/BRIEF.md
# Matrix Blocked-Channel Layout Converter

This block walks a matrix and produces, one element per handshake, a pair of element offsets: where to read the element and where to write it. It converts between plain row-major storage and the blocked channel layout that a convolution engine expects. In that layout the channel axis is split into C1 groups of C2 contiguous elements, and C2 is the innermost dimension. A matrix multiply can then run as a 1x1 convolution. The left operand [M x K] becomes feature data of height M, width 1 and K channels. The right operand [K x N] becomes N kernels, each 1x1 with K channels. The result [M x N] comes back as feature data and is unpacked to row-major.

Software picks the direction (pack or unpack), the operand kind (feature or weight) and the element type (int8 or fp16), gives the row count and the channel count, and pulses start. The block then steps through the destination in order. In pack direction it fills the tail of a partial channel group with zeros. In unpack direction it skips those pad slots. Weights are packed in kernel groups: inside one group, kernels are interleaved per channel group. The block does not touch memory. It only produces offsets.

Top module: `lc_layout_conv`

## Requirements
- R1: After reset valid_o and done_o are low. A start_i seen while idle latches dir_i (0 = pack, 1 = unpack), kind_i (0 = feature, 1 = weight), dtype_i (0 = int8, 1 = fp16), rows_i and cols_i. valid_o is high in the next cycle, with dst_o = 0. A start_i seen while a job runs has no effect on that job's stream.
- R2: The channel group size C2 is 16 for int8 and 8 for fp16. C1 = ceil(cols / C2).
- R3: Feature pack (rows = H, cols = K channels) emits destination offsets 0,1,2,... in order channel-group c1 (outer), row h, lane c2 (inner). The source is h*cols + c1*C2 + c2.
- R4: In pack direction, a slot whose channel c1*C2 + c2 is not below cols is a pad slot. It has zero_o = 1 and src_o = 0. Every other slot has zero_o = 0.
- R5: Weight pack (rows = N kernels, cols = K channels, source B row-major [K x N], element (k,n) at k*N + n) splits the kernels into groups of 32, with a shorter last group of size g. The order is kernel group (outer), channel group c1, kernel within the group, lane c2 (inner). The destination of (n,k) is gbase*C1*C2 + c1*g*C2 + (n - gbase)*C2 + c2.
- R6: Feature unpack walks the destination in row-major order, h outer and channel inner. The destination is h*cols + k and the source is c1*rows*C2 + h*C2 + c2, where c1*C2 + c2 = k. Pad slots are never emitted, so exactly rows*cols pairs come out.
- R7: Weight unpack walks the destination in order k*N + n, k outer, and reads the source from the R5 blocked offset.
- R8: While valid_o is high and ready_i is low, src_o, dst_o and zero_o hold their values.
- R9: done_o is a single-cycle pulse in the cycle after the last accepted pair, with valid_o low. A start with rows_i = 0 or cols_i = 0 emits nothing and pulses done_o in the next cycle.
- R10: Pack emits rows*C1*C2 pairs in all, pad slots included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a job (sampled when idle) |
| dir_i | input | 1 | 0 pack, 1 unpack |
| kind_i | input | 1 | 0 feature, 1 weight |
| dtype_i | input | 1 | 0 int8, 1 fp16 |
| rows_i | input | DIM_W | Rows (feature height or kernel count) |
| cols_i | input | DIM_W | Channel count |
| ready_i | input | 1 | Consumer accepts the current pair |
| valid_o | output | 1 | A pair is presented |
| src_o | output | ADDR_W | Read element offset |
| dst_o | output | ADDR_W | Write element offset |
| zero_o | output | 1 | Write a zero, no read |
| done_o | output | 1 | Job finished pulse |

## Verification
The assertions assume that the consumer may drop ready_i at any time but never needs valid_o to fall without a handshake. They also assume that rows_i times the padded channel count fits in ADDR_W, and that the configuration inputs only matter in the cycle a start is accepted. The stimulus keeps dimensions below 41 and holds ready_i high with a probability of at least a fifth, so every job drains. It also deliberately toggles start_i and the configuration inputs in the middle of a job, to show they are ignored.

// File: rtl/lc_pkg.sv
// Shared encodings for the layout converter.
// Assumes single-bit selects on the top-level ports.
package lc_pkg;
    typedef enum logic { DIR_PACK = 1'b0, DIR_UNPACK = 1'b1 } dir_e;
    typedef enum logic { KIND_FEAT = 1'b0, KIND_WGT = 1'b1 } kind_e;
    typedef enum logic { DT_INT8 = 1'b0, DT_FP16 = 1'b1 } dtype_e;
endpackage

// File: rtl/lc_addr_map.sv
// Combinational coordinate-to-offset mapping.
// Given a row index r (feature row or kernel) and a channel index ch, it gives
// the row-major offset, the blocked offset, the pad flag and the size of the
// kernel group that holds r. Assumes rows > 0 and 2**lgk <= 2**(DIM_W-1).
module lc_addr_map #(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 2 * DIM_W + 2
) (
    input  logic              kind_wgt,
    input  logic [2:0]        sh,
    input  logic [2:0]        lgk,
    input  logic [DIM_W-1:0]  rows,
    input  logic [DIM_W-1:0]  cols,
    input  logic [DIM_W-1:0]  r,
    input  logic [DIM_W:0]    ch,
    output logic [ADDR_W-1:0] rm_addr,
    output logic [ADDR_W-1:0] blk_addr,
    output logic              pad,
    output logic [DIM_W-1:0]  gs
);
    logic [DIM_W-1:0]  gbase, rem;
    logic [DIM_W:0]    kg;
    logic [ADDR_W-1:0] rx, chx, rowsx, colsx, gbx, gsx, c1nx, msk;

    // Kernel-group geometry, then both address forms.
    always_comb begin
        kg    = (DIM_W+1)'(1) << lgk;
        gbase = kind_wgt ? ((r >> lgk) << lgk) : '0;
        rem   = rows - gbase;
        if (!kind_wgt)
            gs = rows;
        else if ({1'b0, rem} > kg)
            gs = kg[DIM_W-1:0];
        else
            gs = rem;
        pad   = ch >= {1'b0, cols};
        rx    = ADDR_W'(r);
        chx   = ADDR_W'(ch);
        rowsx = ADDR_W'(rows);
        colsx = ADDR_W'(cols);
        gbx   = ADDR_W'(gbase);
        gsx   = ADDR_W'(gs);
        msk   = (ADDR_W'(1) << sh) - ADDR_W'(1);
        c1nx  = (colsx + msk) >> sh;
        rm_addr  = kind_wgt ? (chx * rowsx + rx) : (rx * colsx + chx);
        blk_addr = gbx * (c1nx << sh) + (chx >> sh) * (gsx << sh)
                 + ((rx - gbx) << sh) + (chx & msk);
    end
endmodule

// File: rtl/lc_walker.sv
// Nested loop counters that visit the destination in order.
// Pack: kernel-group base, channel group, row in group, lane.
// Unpack: row-major outer/inner indices.
// Assumes rows, cols > 0 while adv is asserted, and gs from lc_addr_map.
module lc_walker #(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic             pack,
    input  logic             kind_wgt,
    input  logic [2:0]       sh,
    input  logic [DIM_W-1:0] rows,
    input  logic [DIM_W-1:0] cols,
    input  logic [DIM_W-1:0] gs,
    output logic [DIM_W-1:0] r_o,
    output logic [DIM_W:0]   ch_o,
    output logic             last_o
);
    logic [DIM_W-1:0] gbase_q, rin_q, c1_q, c2_q, ua_q, ub_q;
    logic [DIM_W-1:0] c2m, c1m, gsm, amax, bmax;
    logic [DIM_W:0]   c1n, gend;

    // Loop limits and current coordinates.
    always_comb begin
        c2m  = (DIM_W'(1) << sh) - DIM_W'(1);
        c1n  = ({1'b0, cols} + {1'b0, c2m}) >> sh;
        c1m  = c1n[DIM_W-1:0] - DIM_W'(1);
        gsm  = gs - DIM_W'(1);
        gend = {1'b0, gbase_q} + {1'b0, gs};
        amax = kind_wgt ? cols - DIM_W'(1) : rows - DIM_W'(1);
        bmax = kind_wgt ? rows - DIM_W'(1) : cols - DIM_W'(1);
        if (pack) begin
            r_o    = gbase_q + rin_q;
            ch_o   = ({1'b0, c1_q} << sh) | {1'b0, c2_q};
            last_o = (c2_q == c2m) && (rin_q == gsm) && (c1_q == c1m)
                   && (gend >= {1'b0, rows});
        end else begin
            r_o    = kind_wgt ? ub_q : ua_q;
            ch_o   = {1'b0, kind_wgt ? ua_q : ub_q};
            last_o = (ua_q == amax) && (ub_q == bmax);
        end
    end

    // Step the innermost counter and carry outwards on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            gbase_q <= '0;
            rin_q   <= '0;
            c1_q    <= '0;
            c2_q    <= '0;
            ua_q    <= '0;
            ub_q    <= '0;
        end else if (adv) begin
            if (pack) begin
                if (c2_q != c2m) begin
                    c2_q <= c2_q + DIM_W'(1);
                end else begin
                    c2_q <= '0;
                    if (rin_q != gsm) begin
                        rin_q <= rin_q + DIM_W'(1);
                    end else begin
                        rin_q <= '0;
                        if (c1_q != c1m) begin
                            c1_q <= c1_q + DIM_W'(1);
                        end else begin
                            c1_q    <= '0;
                            gbase_q <= gbase_q + gs;
                        end
                    end
                end
            end else begin
                if (ub_q != bmax) begin
                    ub_q <= ub_q + DIM_W'(1);
                end else begin
                    ub_q <= '0;
                    ua_q <= ua_q + DIM_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lc_layout_conv.sv
// Top: job control, configuration latch, destination counter and output mux.
// Assumes the consumer honours valid/ready and that rows*C1*C2 fits ADDR_W.
// Configuration inputs are only looked at when a start is accepted.
module lc_layout_conv
    import lc_pkg::*;
#(
    parameter int DIM_W      = 12,
    parameter int ADDR_W     = 2 * DIM_W + 2,
    parameter int LOG_C2_I8  = 4,
    parameter int LOG_C2_F16 = 3,
    parameter int LOG_KG_I8  = 5,
    parameter int LOG_KG_F16 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic              kind_i,
    input  logic              dtype_i,
    input  logic [DIM_W-1:0]  rows_i,
    input  logic [DIM_W-1:0]  cols_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic              zero_o,
    output logic              done_o
);
    dir_e              dir_q;
    kind_e             kind_q;
    dtype_e            dt_q;
    logic [DIM_W-1:0]  rows_q, cols_q, r_w, gs_w;
    logic [DIM_W:0]    ch_w;
    logic [ADDR_W-1:0] dst_q, rm_w, blk_w;
    logic              busy, done_q, accept, empty, fire, last_w, pad_w;
    logic              pack_w, wgt_w;
    logic [2:0]        sh_w, lgk_w;

    // Handshake decode and type-dependent geometry.
    always_comb begin
        accept = start_i && !busy;
        empty  = (rows_i == '0) || (cols_i == '0);
        fire   = busy && ready_i;
        pack_w = (dir_q == DIR_PACK);
        wgt_w  = (kind_q == KIND_WGT);
        sh_w   = (dt_q == DT_FP16) ? 3'(LOG_C2_F16) : 3'(LOG_C2_I8);
        lgk_w  = (dt_q == DT_FP16) ? 3'(LOG_KG_F16) : 3'(LOG_KG_I8);
    end

    // Job state, configuration latch and destination counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done_q <= 1'b0;
            dst_q  <= '0;
            dir_q  <= DIR_PACK;
            kind_q <= KIND_FEAT;
            dt_q   <= DT_INT8;
            rows_q <= '0;
            cols_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                dir_q  <= dir_e'(dir_i);
                kind_q <= kind_e'(kind_i);
                dt_q   <= dtype_e'(dtype_i);
                rows_q <= rows_i;
                cols_q <= cols_i;
                dst_q  <= '0;
                busy   <= !empty;
                done_q <= empty;
            end else if (fire) begin
                dst_q <= dst_q + ADDR_W'(1);
                if (last_w) begin
                    busy   <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    lc_walker #(.DIM_W(DIM_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .adv      (fire),
        .pack     (pack_w),
        .kind_wgt (wgt_w),
        .sh       (sh_w),
        .rows     (rows_q),
        .cols     (cols_q),
        .gs       (gs_w),
        .r_o      (r_w),
        .ch_o     (ch_w),
        .last_o   (last_w)
    );

    lc_addr_map #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_map (
        .kind_wgt (wgt_w),
        .sh       (sh_w),
        .lgk      (lgk_w),
        .rows     (rows_q),
        .cols     (cols_q),
        .r        (r_w),
        .ch       (ch_w),
        .rm_addr  (rm_w),
        .blk_addr (blk_w),
        .pad      (pad_w),
        .gs       (gs_w)
    );

    // Output selection: pack reads row-major, unpack reads blocked.
    always_comb begin
        valid_o = busy;
        dst_o   = dst_q;
        zero_o  = busy && pack_w && pad_w;
        if (pack_w)
            src_o = pad_w ? '0 : rm_w;
        else
            src_o = blk_w;
        done_o  = done_q;
    end
endmodule

// File: rtl/lc_layout_conv_chk.sv
// Protocol and range checks on the converter, attached with bind.
// Assumes the configuration registers inside the top are visible by name.
module lc_layout_conv_chk #(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 2 * DIM_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_o,
    input logic              ready_i,
    input logic [ADDR_W-1:0] src_o,
    input logic [ADDR_W-1:0] dst_o,
    input logic              zero_o,
    input logic              done_o,
    input logic              dir_q,
    input logic [DIM_W-1:0]  rows_q,
    input logic [DIM_W-1:0]  cols_q
);
    logic [ADDR_W-1:0] area;
    // Size of the row-major matrix of the running job.
    always_comb area = ADDR_W'(rows_q) * ADDR_W'(cols_q);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(src_o) && $stable(dst_o) && $stable(zero_o));

    p_dst_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i |=> !valid_o || (dst_o == $past(dst_o) + ADDR_W'(1)));

    p_first_dst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> dst_o == '0);

    p_pad_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && zero_o |-> src_o == '0);

    p_unpack_nopad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && dir_q |-> !zero_o);

    p_src_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !dir_q && !zero_o |-> src_o < area);

    p_dst_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && dir_q |-> dst_o < area);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);
endmodule

bind lc_layout_conv lc_layout_conv_chk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_o (valid_o),
    .ready_i (ready_i),
    .src_o   (src_o),
    .dst_o   (dst_o),
    .zero_o  (zero_o),
    .done_o  (done_o),
    .dir_q   (dir_q),
    .rows_q  (rows_q),
    .cols_q  (cols_q)
);

// File: tb/lc_layout_conv_test.sv
// Self-checking bench: directed corners plus seeded random jobs against a
// reference list built from the requirements.
module lc_layout_conv_test;
    localparam int CLK_P  = 10;
    localparam int DIM_W  = 12;
    localparam int ADDR_W = 2 * DIM_W + 2;
    localparam int MAXE   = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0, dir_i = 1'b0, kind_i = 1'b0, dtype_i = 1'b0;
    logic [DIM_W-1:0]  rows_i = '0, cols_i = '0;
    logic              ready_i = 1'b0;
    logic              valid_o, zero_o, done_o;
    logic [ADDR_W-1:0] src_o, dst_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_src [MAXE];
    int exp_dst [MAXE];
    bit exp_zero[MAXE];
    int n_exp;

    always #(CLK_P/2) clk = ~clk;

    lc_layout_conv #(.DIM_W(DIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .kind_i(kind_i), .dtype_i(dtype_i), .rows_i(rows_i), .cols_i(cols_i),
        .ready_i(ready_i), .valid_o(valid_o), .src_o(src_o), .dst_o(dst_o),
        .zero_o(zero_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exv);
        end
    endtask

    // Blocked offset of (row r, channel ch) from R2, R3, R5.
    function automatic int blk_off(bit wgt, bit fp, int rows, int cols, int r, int ch);
        int c2 = fp ? 8 : 16;
        int c1n = (cols + c2 - 1) / c2;
        int gb, g;
        if (!wgt) return (ch / c2) * rows * c2 + r * c2 + ch % c2;
        gb = (r / 32) * 32;
        g = (rows - gb < 32) ? rows - gb : 32;
        return gb * c1n * c2 + (ch / c2) * g * c2 + (r - gb) * c2 + ch % c2;
    endfunction

    // Expected stream per R3..R7, R10.
    task automatic build_exp(input bit dir, input bit wgt, input bit fp, input int rows, input int cols);
        int c2 = fp ? 8 : 16;
        int c1n = (cols + c2 - 1) / c2;
        int kgs = wgt ? 32 : (rows > 0 ? rows : 1);
        n_exp = 0;
        if (rows == 0 || cols == 0) return;
        if (!dir) begin
            for (int gb = 0; gb < rows; gb += kgs) begin
                int g = (rows - gb < kgs) ? rows - gb : kgs;
                for (int c1 = 0; c1 < c1n; c1++)
                    for (int ni = 0; ni < g; ni++)
                        for (int l = 0; l < c2; l++) begin
                            int ch = c1 * c2 + l;
                            int r = gb + ni;
                            exp_zero[n_exp] = (ch >= cols);
                            exp_src[n_exp] = (ch >= cols) ? 0 : (wgt ? ch * rows + r : r * cols + ch);
                            exp_dst[n_exp] = n_exp;
                            n_exp++;
                        end
            end
        end else begin
            int oa = wgt ? cols : rows;
            int ob = wgt ? rows : cols;
            for (int a = 0; a < oa; a++)
                for (int b = 0; b < ob; b++) begin
                    exp_zero[n_exp] = 1'b0;
                    exp_src[n_exp] = wgt ? blk_off(1'b1, fp, rows, cols, b, a)
                                         : blk_off(1'b0, fp, rows, cols, a, b);
                    exp_dst[n_exp] = n_exp;
                    n_exp++;
                end
        end
    endtask

    // Run one job; called and returning at a falling edge.
    task automatic run_job(input bit dir, input bit wgt, input bit fp, input int rows,
                           input int cols, input int rdy_pct, input bit poke, input string req);
        int idx = 0;
        int cyc = 0;
        bit held = 0;
        logic [ADDR_W-1:0] ps = '0, pd = '0;
        logic pz = 1'b0;
        build_exp(dir, wgt, fp, rows, cols);
        start_i = 1'b1; dir_i = dir; kind_i = wgt; dtype_i = fp;
        rows_i = DIM_W'(rows); cols_i = DIM_W'(cols);
        @(negedge clk);
        start_i = 1'b0;
        if (n_exp == 0) begin
            chk(done_o && !valid_o, "R9", "empty job done/valid", {done_o, valid_o}, 2);
            @(negedge clk);
            chk(!done_o, "R9", "empty job done width", done_o, 0);
            return;
        end
        chk(valid_o && dst_o == 0, "R1", "first pair valid, dst", dst_o, 0);
        while (idx < n_exp && cyc < 30000) begin
            bit rdy;
            if (held)
                chk(src_o == ps && dst_o == pd && zero_o == pz, "R8", "stall hold src", src_o, ps);
            chk(valid_o == 1'b1, req, "valid during job", valid_o, 1);
            chk(src_o == ADDR_W'(exp_src[idx]) && dst_o == ADDR_W'(exp_dst[idx])
                && zero_o == exp_zero[idx], req,
                $sformatf("pair %0d src (dst %0d zero %0d)", idx, dst_o, zero_o),
                src_o, exp_src[idx]);
            if (exp_zero[idx])
                chk(src_o == 0 && zero_o, "R4", "pad slot", src_o, 0);
            rdy = ($urandom % 100) < rdy_pct;
            ready_i = rdy;
            if (poke && idx == 3) begin
                start_i = 1'b1; dir_i = ~dir; kind_i = ~wgt; dtype_i = ~fp;
                rows_i = 7; cols_i = 3;
            end else begin
                start_i = 1'b0;
            end
            if (rdy) begin
                idx++;
                held = 0;
            end else begin
                held = 1;
                ps = src_o; pd = dst_o; pz = zero_o;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        chk(idx == n_exp, req, "pairs accepted (R10 count)", idx, n_exp);
        chk(done_o && !valid_o, "R9", "done after last", {done_o, valid_o}, 2);
        @(negedge clk);
        chk(!done_o && !valid_o, "R9", "done single cycle", done_o, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        chk(!valid_o && !done_o, "R1", "reset state", {valid_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !done_o, "R1", "idle after reset", {valid_o, done_o}, 0);
        // R3 R4 R2: feature pack int8 with partial group, full ready.
        run_job(1'b0, 1'b0, 1'b0, 4, 36, 100, 1'b0, "R3");
        // R2: same matrix in fp16 gives 8-wide groups.
        run_job(1'b0, 1'b0, 1'b1, 4, 36, 100, 1'b0, "R2");
        // R5: 40 kernels fp16 -> groups of 32 and 8.
        run_job(1'b0, 1'b1, 1'b1, 40, 20, 70, 1'b0, "R5");
        // R5: int8 weights, exact group.
        run_job(1'b0, 1'b1, 1'b0, 32, 16, 60, 1'b0, "R5");
        // R6: feature unpack with padding dropped.
        run_job(1'b1, 1'b0, 1'b1, 5, 15, 50, 1'b0, "R6");
        // R7: weight unpack.
        run_job(1'b1, 1'b1, 1'b0, 35, 9, 50, 1'b0, "R7");
        // R8: heavy back-pressure.
        run_job(1'b0, 1'b0, 1'b1, 3, 10, 20, 1'b0, "R8");
        // R1: start and config toggles during a job are ignored.
        run_job(1'b0, 1'b1, 1'b1, 33, 12, 60, 1'b1, "R1");
        // R9: empty dimensions.
        run_job(1'b0, 1'b0, 1'b0, 0, 12, 100, 1'b0, "R9");
        run_job(1'b1, 1'b1, 1'b1, 9, 0, 100, 1'b0, "R9");
        // R10: single element, pack fills the whole group.
        run_job(1'b0, 1'b0, 1'b0, 1, 1, 100, 1'b0, "R10");
        for (int j = 0; j < 14; j++) begin
            bit d = 1'($urandom);
            bit w = 1'($urandom);
            bit f = 1'($urandom);
            int rr = 1 + $urandom % 40;
            int cc = 1 + $urandom % 40;
            run_job(d, w, f, rr, cc, 30 + $urandom % 71, 1'($urandom),
                    d ? (w ? "R7" : "R6") : (w ? "R5" : "R3"));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule